// File: doc/BRIEF.md
# Frame Store Pointer Sequencer

This block decides which frame buffer a video DMA channel uses for each frame. It keeps two independent frame indices: one for the read channel, which streams from memory, and one for the write channel, which streams into memory. Each index moves only when its channel's frame-sync pulse arrives.

A channel either rotates through the active frame stores in turn or stays parked on one store. The parked store comes from a 16-bit park word. In genlock mode the read channel instead follows the write channel, lagging it by a programmable number of frames.

The number of active stores is a runtime input, clamped to the build-time maximum. Both indices are also packed into a read-only status word. Address generation and data movement sit in other blocks.

Top module: `fsp_sequencer`

## Requirements
- R1: While reset is asserted and right after it, both indices are 0 and the status word is 0.
- R2: The active store count N is `store_count` clamped to the range 1..MAX_STORES. A value of 0 counts as 1, and a value above MAX_STORES counts as MAX_STORES.
- R3: A channel's index changes only on the clock edge where that channel's own frame-sync input is high. Without that pulse it holds, even when the other channel pulses or the configuration changes.
- R4: With circular mode on, a frame sync moves the index to index+1. If index+1 is greater than or equal to N, the index wraps to 0 instead.
- R5: With circular mode off, a frame sync loads the park field, provided the field is less than N. The read channel's park field is `park_ptr[7:0]` and the write channel's is `park_ptr[15:8]`.
- R6: With circular mode off, a frame sync whose 8-bit park field is greater than or equal to N leaves the index unchanged.
- R7: When `genlock_en` is high, a read frame sync loads (W + N − (D mod N)) mod N. W is the write index held just before that edge and D is `follow_delay`. Genlock takes priority over the circular and park settings of the read channel.
- R8: `ptr_status` carries the read index zero-extended in bits 7:0 and the write index zero-extended in bits 15:8. Bits 31:16 are 0.
- R9: `genlock_en` has no effect on the write channel. That channel always follows its own circular or park setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_rd | input | 1 | Read-channel frame-sync pulse |
| fsync_wr | input | 1 | Write-channel frame-sync pulse |
| store_count | input | 8 | Requested number of active frame stores |
| circ_rd | input | 1 | Read-channel circular enable (0 = park) |
| circ_wr | input | 1 | Write-channel circular enable (0 = park) |
| park_ptr | input | 16 | Park fields: read in 7:0, write in 15:8 |
| genlock_en | input | 1 | Read channel follows the write index |
| follow_delay | input | 8 | Frame lag of the follower |
| rd_idx | output | IDX_W | Current read frame index |
| wr_idx | output | IDX_W | Current write frame index |
| ptr_status | output | 32 | Packed read-only index status |

## Verification
Directed runs cover the following cases:
- Circular rotation with a small N, which exposes off-by-one errors in the wrap point.
- Store counts of 0 and above the maximum, which separate correct clamping from raw use of the input.
- Park fields just inside and just outside N, which separate honouring a park from ignoring it.
- Genlock with delays both below and above N, which separate a true modulo lag from a plain subtraction.

Seeded random frames then mix pulses on one channel or both with changing modes and counts. These runs catch cross-channel coupling, and cases where the follower reads the write index after the edge instead of before it.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   localparam int unsigned FIELD_W     = 8;
   localparam int unsigned RD_FIELD_LO = 0;
   localparam int unsigned WR_FIELD_LO = 8;
   localparam int unsigned STATUS_W    = 32;

   typedef enum logic [1:0] {
      SEQ_HOLD,
      SEQ_STEP,
      SEQ_PARK,
      SEQ_FOLLOW
   } seq_op_e;
endpackage

// File: rtl/fsp_store_clamp.sv
module fsp_store_clamp #(
   parameter int unsigned MAX_STORES = 8,
   parameter int unsigned CNT_W      = 4
) (
   input  logic [7:0]       req_count,
   output logic [CNT_W-1:0] n_eff
);
   always_comb begin
      if (req_count == 8'd0) begin
         n_eff = CNT_W'(1);
      end else if (32'(req_count) > MAX_STORES) begin
         n_eff = CNT_W'(MAX_STORES);
      end else begin
         n_eff = CNT_W'(req_count);
      end
   end
endmodule

// File: rtl/fsp_lag_calc.sv
module fsp_lag_calc #(
   parameter int unsigned IDX_W = 3,
   parameter int unsigned CNT_W = 4
) (
   input  logic [IDX_W-1:0] master_idx,
   input  logic [CNT_W-1:0] n_eff,
   input  logic [7:0]       delay,
   output logic [IDX_W-1:0] target
);
   localparam int unsigned AW = 10;

   logic [AW-1:0] lag;
   logic [AW-1:0] sum;
   logic [AW-1:0] wrapped;

   always_comb begin
      lag     = AW'(delay) % AW'(n_eff);
      sum     = AW'(master_idx) + AW'(n_eff) - lag;
      wrapped = sum % AW'(n_eff);
      target  = wrapped[IDX_W-1:0];
   end
endmodule

// File: rtl/fsp_idx_seq.sv
module fsp_idx_seq
   import fsp_pkg::*;
#(
   parameter int unsigned IDX_W = 3,
   parameter int unsigned CNT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fsync,
   input  logic               circ_en,
   input  logic               follow_en,
   input  logic [FIELD_W-1:0] park_fld,
   input  logic [IDX_W-1:0]   follow_tgt,
   input  logic [CNT_W-1:0]   n_eff,
   output logic [IDX_W-1:0]   idx
);
   seq_op_e          op;
   logic             park_ok;
   logic             wrap;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_d;

   assign park_ok = 32'(park_fld) < 32'(n_eff);
   assign wrap    = (32'(idx_q) + 32'd1) >= 32'(n_eff);

   always_comb begin
      if (!fsync) begin
         op = SEQ_HOLD;
      end else if (follow_en) begin
         op = SEQ_FOLLOW;
      end else if (circ_en) begin
         op = SEQ_STEP;
      end else if (park_ok) begin
         op = SEQ_PARK;
      end else begin
         op = SEQ_HOLD;
      end
   end

   always_comb begin
      unique case (op)
         SEQ_STEP:   idx_d = wrap ? '0 : idx_q + IDX_W'(1);
         SEQ_PARK:   idx_d = park_fld[IDX_W-1:0];
         SEQ_FOLLOW: idx_d = follow_tgt;
         default:    idx_d = idx_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else begin
         idx_q <= idx_d;
      end
   end

   assign idx = idx_q;
endmodule

// File: rtl/fsp_sequencer.sv
module fsp_sequencer
   import fsp_pkg::*;
#(
   parameter int unsigned MAX_STORES  = 8,
   parameter bit          HAS_GENLOCK = 1'b1,
   localparam int unsigned IDX_W = (MAX_STORES > 1) ? $clog2(MAX_STORES) : 1,
   localparam int unsigned CNT_W = $clog2(MAX_STORES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fsync_rd,
   input  logic                fsync_wr,
   input  logic [7:0]          store_count,
   input  logic                circ_rd,
   input  logic                circ_wr,
   input  logic [15:0]         park_ptr,
   input  logic                genlock_en,
   input  logic [7:0]          follow_delay,
   output logic [IDX_W-1:0]    rd_idx,
   output logic [IDX_W-1:0]    wr_idx,
   output logic [STATUS_W-1:0] ptr_status
);
   localparam int unsigned NCH = 2;

   if (MAX_STORES < 1 || MAX_STORES > 32) begin : g_bad_cfg
      $error("fsp_sequencer: MAX_STORES must be within 1..32");
   end

   logic [CNT_W-1:0] n_eff;
   logic [NCH-1:0]   fsync_v;
   logic [NCH-1:0]   circ_v;
   logic [NCH-1:0]   follow_v;
   logic [IDX_W-1:0] idx_v [NCH];
   logic [IDX_W-1:0] follow_tgt;

   assign fsync_v = {fsync_wr, fsync_rd};
   assign circ_v  = {circ_wr, circ_rd};

   fsp_store_clamp #(
      .MAX_STORES (MAX_STORES),
      .CNT_W      (CNT_W)
   ) u_clamp (
      .req_count (store_count),
      .n_eff     (n_eff)
   );

   if (HAS_GENLOCK) begin : g_genlock
      fsp_lag_calc #(
         .IDX_W (IDX_W),
         .CNT_W (CNT_W)
      ) u_lag (
         .master_idx (idx_v[1]),
         .n_eff      (n_eff),
         .delay      (follow_delay),
         .target     (follow_tgt)
      );
      assign follow_v = {1'b0, genlock_en};
   end else begin : g_no_genlock
      assign follow_tgt = '0;
      assign follow_v   = '0;
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam int unsigned LO = (ch == 0) ? RD_FIELD_LO : WR_FIELD_LO;
      fsp_idx_seq #(
         .IDX_W (IDX_W),
         .CNT_W (CNT_W)
      ) u_seq (
         .clk        (clk),
         .rst_n      (rst_n),
         .fsync      (fsync_v[ch]),
         .circ_en    (circ_v[ch]),
         .follow_en  (follow_v[ch]),
         .park_fld   (park_ptr[LO +: FIELD_W]),
         .follow_tgt (follow_tgt),
         .n_eff      (n_eff),
         .idx        (idx_v[ch])
      );
   end

   assign rd_idx = idx_v[0];
   assign wr_idx = idx_v[1];

   always_comb begin
      ptr_status = '0;
      ptr_status[RD_FIELD_LO +: FIELD_W] = FIELD_W'(idx_v[0]);
      ptr_status[WR_FIELD_LO +: FIELD_W] = FIELD_W'(idx_v[1]);
   end
endmodule

// File: rtl/fsp_sequencer_chk.sv
module fsp_sequencer_chk #(
   parameter int unsigned MAX_STORES = 8,
   parameter int unsigned IDX_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fsync_rd,
   input logic             fsync_wr,
   input logic [7:0]       store_count,
   input logic             circ_rd,
   input logic             circ_wr,
   input logic [15:0]      park_ptr,
   input logic             genlock_en,
   input logic [IDX_W-1:0] rd_idx,
   input logic [IDX_W-1:0] wr_idx,
   input logic [31:0]      ptr_status
);
   int unsigned n_chk;

   always_comb begin
      if (store_count == 8'd0)                 n_chk = 1;
      else if (32'(store_count) > MAX_STORES)  n_chk = MAX_STORES;
      else                                     n_chk = 32'(store_count);
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fsync_rd |=> rd_idx == $past(rd_idx)); // R3
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fsync_wr |=> wr_idx == $past(wr_idx)); // R3
   AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_wr && circ_wr && (32'(wr_idx) + 1 < n_chk)
      |=> 32'(wr_idx) == 32'($past(wr_idx)) + 1); // R4
   AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_wr && circ_wr && (32'(wr_idx) + 1 >= n_chk) |=> wr_idx == '0); // R4
   AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_rd && !genlock_en && circ_rd && (32'(rd_idx) + 1 >= n_chk)
      |=> rd_idx == '0); // R4
   AST_WR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_wr && !circ_wr && (32'(park_ptr[15:8]) < n_chk)
      |=> 32'(wr_idx) == 32'($past(park_ptr[15:8]))); // R5
   AST_RD_PARK_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_rd && !genlock_en && !circ_rd && (32'(park_ptr[7:0]) >= n_chk)
      |=> rd_idx == $past(rd_idx)); // R6
   AST_STATUS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_status[31:16] == 16'd0); // R8
endmodule

bind fsp_sequencer fsp_sequencer_chk #(
   .MAX_STORES (MAX_STORES),
   .IDX_W      (IDX_W)
) u_fsp_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fsync_rd    (fsync_rd),
   .fsync_wr    (fsync_wr),
   .store_count (store_count),
   .circ_rd     (circ_rd),
   .circ_wr     (circ_wr),
   .park_ptr    (park_ptr),
   .genlock_en  (genlock_en),
   .rd_idx      (rd_idx),
   .wr_idx      (wr_idx),
   .ptr_status  (ptr_status)
);

// File: tb/test_fsp_sequencer.sv
module test_fsp_sequencer;
   localparam int unsigned MAXS  = 8;
   localparam int unsigned IDX_W = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             fsync_rd, fsync_wr, circ_rd, circ_wr, genlock_en;
   logic [7:0]       store_count, follow_delay;
   logic [15:0]      park_ptr;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [31:0]      ptr_status;

   int checks = 0;
   int errors = 0;
   int m_rd = 0;
   int m_wr = 0;

   always #5 clk = ~clk;

   fsp_sequencer #(.MAX_STORES(MAXS), .HAS_GENLOCK(1'b1)) i_fsp_sequencer (
      .clk(clk), .rst_n(rst_n), .fsync_rd(fsync_rd), .fsync_wr(fsync_wr),
      .store_count(store_count), .circ_rd(circ_rd), .circ_wr(circ_wr),
      .park_ptr(park_ptr), .genlock_en(genlock_en), .follow_delay(follow_delay),
      .rd_idx(rd_idx), .wr_idx(wr_idx), .ptr_status(ptr_status)
   );

   function automatic int eff_n(int req);
      if (req == 0) return 1;
      if (req > int'(MAXS)) return MAXS;
      return req;
   endfunction

   function automatic int next_idx(int cur, bit fs, bit circ, bit fol,
                                   int park, int n, int w_before, int dly);
      if (!fs) return cur;
      if (fol) return (w_before + n - (dly % n)) % n;
      if (circ) return (cur + 1 >= n) ? 0 : cur + 1;
      if (park < n) return park;
      return cur;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic frame(string req, bit fr, bit fw, bit cr, bit cw, bit gl,
                        int prd, int pwr, int cnt, int dly);
      int n;
      int nrd;
      int nwr;
      @(negedge clk);
      fsync_rd = fr; fsync_wr = fw; circ_rd = cr; circ_wr = cw;
      genlock_en = gl; park_ptr = {8'(pwr), 8'(prd)};
      store_count = 8'(cnt); follow_delay = 8'(dly);
      n   = eff_n(cnt);
      nrd = next_idx(m_rd, fr, cr, gl, prd, n, m_wr, dly);
      nwr = next_idx(m_wr, fw, cw, 1'b0, pwr, n, m_wr, dly);
      m_rd = nrd;
      m_wr = nwr;
      @(posedge clk);
      #1;
      chk({req, " rd_idx"}, int'(rd_idx), m_rd);
      chk({req, " wr_idx"}, int'(wr_idx), m_wr);
      chk({"R8 status after ", req}, int'(ptr_status), (m_wr << 8) | m_rd);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; fsync_rd = 1'b0; fsync_wr = 1'b0; circ_rd = 1'b1;
      circ_wr = 1'b1; genlock_en = 1'b0; park_ptr = '0; store_count = 8'd4;
      follow_delay = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 rd reset", int'(rd_idx), 0);
      chk("R1 wr reset", int'(wr_idx), 0);
      chk("R1 status reset", int'(ptr_status), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: rotation through 3 stores with wrap
      for (int i = 0; i < 5; i++) frame("R4 circ", 1, 1, 1, 1, 0, 0, 0, 3, 0);
      // R3: no pulse holds; one channel pulse leaves the other alone
      frame("R3 no sync", 0, 0, 1, 1, 0, 1, 2, 7, 0);
      frame("R3 rd only", 1, 0, 0, 0, 0, 1, 2, 3, 0);
      frame("R3 wr only", 0, 1, 1, 1, 0, 0, 0, 3, 0);
      // R5 / R6: park inside and outside range
      frame("R5 park", 1, 1, 0, 0, 0, 2, 1, 3, 0);
      frame("R6 park ignored", 1, 1, 0, 0, 0, 5, 3, 3, 0);
      frame("R6 park big field", 1, 1, 0, 0, 0, 200, 255, 3, 0);
      // R2: zero count and count above maximum
      frame("R2 zero count", 1, 1, 1, 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 10; i++) frame("R2 clamp high", 1, 1, 1, 1, 0, 0, 0, 20, 0);
      frame("R2 park at max", 1, 1, 0, 0, 0, 7, 7, 40, 0);
      // R7 / R9: genlock following with small and large delay
      for (int i = 0; i < 4; i++) frame("R7 lag2", 1, 1, 1, 1, 1, 0, 0, 5, 2);
      for (int i = 0; i < 4; i++) frame("R7 lag mod", 1, 1, 0, 1, 1, 0, 4, 5, 7);
      frame("R7 same edge", 1, 1, 0, 1, 1, 0, 0, 5, 0);
      frame("R9 wr park under genlock", 1, 1, 0, 0, 1, 0, 3, 5, 1);

      // mixed seeded random frames
      void'($urandom(32'd2024));
      for (int i = 0; i < 600; i++) begin
         int cnt;
         cnt = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 11);
         frame("R3/R4/R5/R6/R7 random",
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 3 == 0), int'($urandom % 10), int'($urandom % 10),
               cnt, int'($urandom % 256));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule